// File: doc/BRIEF.md
# PCI Command and Status Register Block

This block holds the 16-bit command word and the 16-bit status word that a PCI-style bus bridge exposes in its configuration header. Configuration writes with per-byte enables update the writable command bits and clear the sticky error flags. Configuration reads return the two words packed into one 32-bit value, with the command word in the low half and the status word in the high half. The read value is registered.

The bridge's master and slave engines report events to the block as single-cycle pulses. These are a parity error seen on the bus, a parity error driven by the bridge, a transfer mastered by the bridge, a target-abort issued by the slave side, a target-abort received by the master side, and a system-error event. The block records the error events in sticky status flags.

The command bits gate four things outside the block. They gate the memory-target decode, they gate permission to master the bus, they enable parity checking, and they gate the system-error pin driver.

Top module: `pci_cmdstat`

## Requirements
- R1: After reset, every writable command bit and every status flag is 0, `par_chk_en` and `serr_out` are low, and the first read returns 0x0280_0000.
- R2: A write updates command bit 1 (memory enable), bit 2 (master enable) and bit 6 (parity response) only when `cfg_be[0]` is set. It updates bit 8 (system-error enable) only when `cfg_be[1]` is set. All other command bits always read 0.
- R3: `mem_sel` equals `mem_hit` while the memory enable bit is 1, and it stays 0 while that bit is 0.
- R4: `mst_ok` equals `mst_req` while the master enable bit is 1, and it stays 0 while that bit is 0.
- R5: `par_chk_en` always equals the parity response bit.
- R6: `serr_out` is high in the cycle after an `ev_sys_err` pulse if the system-error enable bit was 1 at that edge. It is never high otherwise.
- R7: Bit 23 (fast back-to-back capable) always reads 1, and bits 26:25 (select timing) always read 01. Writes never change them.
- R8: Bit 24 (data parity) sets at an edge only when all three of these hold: (`ev_perr_seen` or `ev_perr_drv`), `ev_mst_xfer`, and the parity response bit is 1.
- R9: Bit 27 (signalled target-abort) sets at every edge where `ev_tabort_sig` is high.
- R10: Bit 28 (received target-abort) sets at every edge where `ev_tabort_rcv` is high.
- R11: Each flag at bits 24, 27 and 28 clears when it is written with 1 under `cfg_be[3]`. A written 0, or a write with `cfg_be[3]` clear, leaves it unchanged.
- R12: When a flag's set event and its write-1-to-clear arrive at the same edge, the flag ends up at 1.
- R13: `cfg_rdata` loads the register value as it stood before the edge at which `cfg_rd` is high, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ev_perr_seen | input | 1 | Parity error observed on the bus |
| ev_perr_drv | input | 1 | Parity error driven by this bridge |
| ev_mst_xfer | input | 1 | Current transfer is mastered by this bridge |
| ev_tabort_sig | input | 1 | Slave side ended a transfer with target-abort |
| ev_tabort_rcv | input | 1 | Mastered transfer was ended by target-abort |
| ev_sys_err | input | 1 | System-error event |
| mem_hit | input | 1 | Raw memory-space address match |
| mst_req | input | 1 | Master engine wants to start a transaction |
| mem_sel | output | 1 | Gated memory-target decode |
| mst_ok | output | 1 | Gated master permission |
| par_chk_en | output | 1 | Parity checking enable |
| serr_out | output | 1 | System-error pin drive, active high |

## Verification
The gating outputs `mem_sel`, `mst_ok` and `par_chk_en` are combinational from the register state and the current inputs. The bench therefore checks them in the same cycle, shortly after it drives the inputs.

Register updates, flag sets and clears, `serr_out` and `cfg_rdata` all take effect at the next rising edge. The bench advances its reference model at that edge. It compares these outputs at the following falling edge, where a read captures the state from before that edge.

Random cycles with a fixed seed cover the bulk of the patterns. Directed sequences cover the reset value, the set-versus-clear collision, written zeros, and writes with the byte enables cleared.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  // command word positions
  localparam int C_MEM  = 1;
  localparam int C_MST  = 2;
  localparam int C_PAR  = 6;
  localparam int C_SERR = 8;

  // status positions within the 32-bit view
  localparam int S_FAST   = 16 + 7;
  localparam int S_DPAR   = 16 + 8;
  localparam int S_TIM_LO = 16 + 9;
  localparam int S_SIGTA  = 16 + 11;
  localparam int S_RCVTA  = 16 + 12;
  localparam logic [1:0] TIM_MEDIUM = 2'b01;

  localparam int NFLAG = 3;

  typedef struct packed {
    logic serr_en;
    logic par_en;
    logic mst_en;
    logic mem_en;
  } cmd_t;

  function automatic int flag_pos(input int idx);
    case (idx)
      0:       flag_pos = S_DPAR;
      1:       flag_pos = S_SIGTA;
      default: flag_pos = S_RCVTA;
    endcase
  endfunction
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_cmd_reg.sv
module pcs_cmd_reg
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  output cmd_t              cmd_q
);
  localparam int MEM_B  = C_MEM / 8;
  localparam int MST_B  = C_MST / 8;
  localparam int PAR_B  = C_PAR / 8;
  localparam int SERR_B = C_SERR / 8;

  cmd_t cmd_d;
  logic cmd_ce;

  always_comb begin
    cmd_d  = cmd_q;
    cmd_ce = wr;
    if (be[MEM_B])  cmd_d.mem_en  = wdata[C_MEM];
    if (be[MST_B])  cmd_d.mst_en  = wdata[C_MST];
    if (be[PAR_B])  cmd_d.par_en  = wdata[C_PAR];
    if (be[SERR_B]) cmd_d.serr_en = wdata[C_SERR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_ce) cmd_q <= cmd_d;
  end

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cmd_q));
  assert_serr_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !be[SERR_B]) |=> $stable(cmd_q.serr_en));
endmodule

// File: rtl/pcs_flag.sv
module pcs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = set_i | clr_i;
    flag_d  = set_i;      // set dominates a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/pcs_status.sv
module pcs_status
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              par_en,
  input  logic              perr_seen,
  input  logic              perr_drv,
  input  logic              mst_xfer,
  input  logic              tabort_sig,
  input  logic              tabort_rcv,
  output logic [NFLAG-1:0]  flags_q
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;

  always_comb begin
    set_v[0] = (perr_seen | perr_drv) & mst_xfer & par_en;
    set_v[1] = tabort_sig;
    set_v[2] = tabort_rcv;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    assign clr_v[i] = wr & be[POS/8] & wdata[POS];
    pcs_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .flag_q (flags_q[i])
    );
  end

  assert_dpar_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[0] && !(mst_xfer && par_en)) |=> !flags_q[0]);
  assert_sigta_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tabort_sig |=> flags_q[1]);
  assert_rcvta_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tabort_rcv |=> flags_q[2]);
endmodule

// File: rtl/pcs_gate.sv
module pcs_gate
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic mem_hit,
  input  logic mst_req,
  input  logic sys_err,
  output logic mem_sel,
  output logic mst_ok,
  output logic par_chk_en,
  output logic serr_out
);
  logic serr_d;

  always_comb begin
    mem_sel    = mem_hit & cmd.mem_en;
    mst_ok     = mst_req & cmd.mst_en;
    par_chk_en = cmd.par_en;
    serr_d     = sys_err & cmd.serr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_out <= 1'b0;
    else        serr_out <= serr_d;
  end

  assert_mem_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.mem_en |-> !mem_sel);
  assert_mst_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.mst_en |-> !mst_ok);
  assert_serr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.serr_en && sys_err) |=> !serr_out);
endmodule

// File: rtl/pci_cmdstat.sv
module pci_cmdstat
  import pcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ev_perr_seen,
  input  logic        ev_perr_drv,
  input  logic        ev_mst_xfer,
  input  logic        ev_tabort_sig,
  input  logic        ev_tabort_rcv,
  input  logic        ev_sys_err,
  input  logic        mem_hit,
  input  logic        mst_req,
  output logic        mem_sel,
  output logic        mst_ok,
  output logic        par_chk_en,
  output logic        serr_out
);
  logic             rst_i_n;
  cmd_t             cmd_q;
  logic [NFLAG-1:0] flags_q;
  logic [31:0]      reg_view;
  logic [31:0]      rdata_d;

  pcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pcs_cmd_reg u_cmd (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .cmd_q (cmd_q)
  );

  pcs_status u_stat (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr         (cfg_wr),
    .be         (cfg_be),
    .wdata      (cfg_wdata),
    .par_en     (cmd_q.par_en),
    .perr_seen  (ev_perr_seen),
    .perr_drv   (ev_perr_drv),
    .mst_xfer   (ev_mst_xfer),
    .tabort_sig (ev_tabort_sig),
    .tabort_rcv (ev_tabort_rcv),
    .flags_q    (flags_q)
  );

  pcs_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .cmd        (cmd_q),
    .mem_hit    (mem_hit),
    .mst_req    (mst_req),
    .sys_err    (ev_sys_err),
    .mem_sel    (mem_sel),
    .mst_ok     (mst_ok),
    .par_chk_en (par_chk_en),
    .serr_out   (serr_out)
  );

  always_comb begin
    reg_view                      = '0;
    reg_view[C_MEM]               = cmd_q.mem_en;
    reg_view[C_MST]               = cmd_q.mst_en;
    reg_view[C_PAR]               = cmd_q.par_en;
    reg_view[C_SERR]              = cmd_q.serr_en;
    reg_view[S_FAST]              = 1'b1;
    reg_view[S_TIM_LO+1:S_TIM_LO] = TIM_MEDIUM;
    for (int i = 0; i < NFLAG; i++) reg_view[flag_pos(i)] = flags_q[i];
    rdata_d = reg_view;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rdata_d;
  end

  assert_const_bits_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_rd |=> (cfg_rdata[S_TIM_LO+1:S_TIM_LO] == TIM_MEDIUM) && cfg_rdata[S_FAST]);
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_rd |=> $stable(cfg_rdata));
  assert_par_out_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_rd |=> (cfg_rdata[C_PAR] == $past(par_chk_en)));
endmodule

// File: tb/pci_cmdstat_tb.sv
module pci_cmdstat_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        ev_perr_seen, ev_perr_drv, ev_mst_xfer;
  logic        ev_tabort_sig, ev_tabort_rcv, ev_sys_err;
  logic        mem_hit, mst_req;
  logic        mem_sel, mst_ok, par_chk_en, serr_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic m_mem, m_mst, m_par, m_serr, m_dp, m_sta, m_rta, m_serr_out;
  logic [31:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cmdstat u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_perr_seen(ev_perr_seen), .ev_perr_drv(ev_perr_drv),
    .ev_mst_xfer(ev_mst_xfer), .ev_tabort_sig(ev_tabort_sig),
    .ev_tabort_rcv(ev_tabort_rcv), .ev_sys_err(ev_sys_err),
    .mem_hit(mem_hit), .mst_req(mst_req), .mem_sel(mem_sel),
    .mst_ok(mst_ok), .par_chk_en(par_chk_en), .serr_out(serr_out)
  );

  function automatic logic [31:0] model_view();
    logic [31:0] v = '0;
    v[1] = m_mem; v[2] = m_mst; v[6] = m_par; v[8] = m_serr;
    v[23] = 1'b1; v[26:25] = 2'b01;
    v[24] = m_dp; v[27] = m_sta; v[28] = m_rta;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle();
    cfg_wr = 0; cfg_rd = 0; cfg_be = 0; cfg_wdata = 0;
    ev_perr_seen = 0; ev_perr_drv = 0; ev_mst_xfer = 0;
    ev_tabort_sig = 0; ev_tabort_rcv = 0; ev_sys_err = 0;
    mem_hit = 0; mst_req = 0;
  endtask

  task automatic model_reset();
    m_mem = 0; m_mst = 0; m_par = 0; m_serr = 0;
    m_dp = 0; m_sta = 0; m_rta = 0; m_serr_out = 0; m_rdata = '0;
  endtask

  // inputs already driven (after a negedge); checks and advances one cycle
  task automatic step();
    logic dp_set, clr3;
    #1;
    check("R3 mem_sel", {31'b0, mem_sel}, {31'b0, mem_hit & m_mem});
    check("R4 mst_ok", {31'b0, mst_ok}, {31'b0, mst_req & m_mst});
    check("R5 par_chk_en", {31'b0, par_chk_en}, {31'b0, m_par});
    @(posedge clk);
    if (cfg_rd) m_rdata = model_view();
    m_serr_out = ev_sys_err & m_serr;
    dp_set = (ev_perr_seen | ev_perr_drv) & ev_mst_xfer & m_par;
    clr3 = cfg_wr & cfg_be[3];
    m_dp  = dp_set        | (m_dp  & ~(clr3 & cfg_wdata[24]));
    m_sta = ev_tabort_sig | (m_sta & ~(clr3 & cfg_wdata[27]));
    m_rta = ev_tabort_rcv | (m_rta & ~(clr3 & cfg_wdata[28]));
    if (cfg_wr && cfg_be[0]) begin
      m_mem = cfg_wdata[1]; m_mst = cfg_wdata[2]; m_par = cfg_wdata[6];
    end
    if (cfg_wr && cfg_be[1]) m_serr = cfg_wdata[8];
    @(negedge clk);
    check("R6 serr_out", {31'b0, serr_out}, {31'b0, m_serr_out});
    check("R13 rdata (R2 R7 R8 R9 R10 R11 R12)", cfg_rdata, m_rdata);
  endtask

  task automatic do_read(input string req);
    idle(); cfg_rd = 1; step();
    check(req, cfg_rdata, model_view());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset value
    check("R1 par_chk_en reset", {31'b0, par_chk_en}, 32'd0);
    check("R1 serr_out reset", {31'b0, serr_out}, 32'd0);
    do_read("R1 reset read");
    check("R1 reset literal", cfg_rdata, 32'h0280_0000);

    // R2 enable all command bits, attempt to write constants (R7)
    idle(); cfg_wr = 1; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF; step();
    do_read("R7 constants after write of ones");
    check("R2 command readback", cfg_rdata & 32'h0000_FFFF, 32'h0000_0146);

    // R6 serr driven when enabled
    idle(); ev_sys_err = 1; step();
    check("R6 serr asserted", {31'b0, serr_out}, 32'd1);

    // R8 partial conditions do not set, full set does
    idle(); ev_perr_seen = 1; step();
    idle(); ev_mst_xfer = 1; step();
    do_read("R8 no set on partial conditions");
    idle(); ev_perr_drv = 1; ev_mst_xfer = 1; step();
    do_read("R8 set on all three");

    // R12 set and clear together; R11 write of zero
    idle(); cfg_wr = 1; cfg_be = 4'h8; cfg_wdata = 32'h1800_0000;
    ev_tabort_sig = 1; ev_tabort_rcv = 1; step();
    do_read("R12 set wins");
    check("R12 abort flags set", cfg_rdata & 32'h1800_0000, 32'h1800_0000);
    idle(); cfg_wr = 1; cfg_be = 4'h8; cfg_wdata = 32'h0; step();
    do_read("R11 zero write leaves flags");
    idle(); cfg_wr = 1; cfg_be = 4'h7; cfg_wdata = 32'hFFFF_FFFF; step();
    do_read("R11 no clear without byte 3");
    idle(); cfg_wr = 1; cfg_be = 4'h8; cfg_wdata = 32'h1900_0000; step();
    do_read("R11 clear by ones");
    check("R11 flags cleared", cfg_rdata & 32'h1900_0000, 32'h0);

    // R2 serr enable untouched without byte 1, then R6 disabled
    idle(); cfg_wr = 1; cfg_be = 4'h1; cfg_wdata = 32'h0; step();
    do_read("R2 byte 0 only");
    idle(); cfg_wr = 1; cfg_be = 4'h2; cfg_wdata = 32'h0; step();
    idle(); ev_sys_err = 1; step();
    check("R6 serr blocked", {31'b0, serr_out}, 32'd0);
    // R8 parity response off blocks the flag
    idle(); ev_perr_seen = 1; ev_mst_xfer = 1; step();
    do_read("R8 blocked when parity response off");

    // random phase, R9 R10 R13 and all others
    for (int n = 0; n < 3000; n++) begin
      idle();
      cfg_wr        = ($urandom % 4) == 0;
      cfg_rd        = ($urandom % 2) == 0;
      cfg_be        = 4'($urandom);
      cfg_wdata     = $urandom;
      ev_perr_seen  = ($urandom % 5) == 0;
      ev_perr_drv   = ($urandom % 5) == 0;
      ev_mst_xfer   = ($urandom % 2) == 0;
      ev_tabort_sig = ($urandom % 8) == 0;
      ev_tabort_rcv = ($urandom % 8) == 0;
      ev_sys_err    = ($urandom % 4) == 0;
      mem_hit       = ($urandom % 2) == 0;
      mst_req       = ($urandom % 2) == 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule